// File: doc/BRIEF.md
# Rename Stage Thread Controller

This block is the control half of a register-rename pipeline stage that serves several hardware threads. For every thread it runs a small state machine and decides each cycle how many instructions may rename. The decision takes in the free space left in the reorder buffer, the issue queue and the load/store queue. It also reacts to stall requests from later stages, to squashes and to serializing instructions. The datapath that holds the instructions, the map tables and the skid storage sits outside. This block only tells that datapath how many entries to rename, push and pop.

Each thread counts the instructions it has sent onward that the downstream occupancy figures do not yet include. It subtracts that count from every free-entry input before it compares them. When the room left is smaller than what is waiting, the thread renames what fits and reports which structure ran short. It then enters Blocked and keeps decode held off while arrivals collect in its skid buffer. It drains that buffer in Unblocking and releases decode only once the buffer is empty.

A serializing instruction waits until the reorder buffer is empty and nothing is in flight toward it, and then it renames alone. A serialize-after marker makes the next instruction behave the same way. A squash overrides everything else.

Top module: `rename_ctrl`

## Requirements
- R1: After a synchronous reset every thread is Idle: no grant, block low, flush low, and the activity flag low.
- R2: The source is the skid count when that count is nonzero, otherwise the decode count. In Running or Idle, with no stall request and no serializing head, the grant equals the smallest of the rename width, the source count and each structure's room.
- R3: Each structure's room is its free count minus the thread's in-flight count, floored at zero. The in-flight count gains the grant and loses the retire input each cycle, and a squash clears it.
- R4: The cause output uses code 0 for the reorder buffer, 1 for the issue queue, 2 for the load/store queue and 3 for none. When several structures lack room for the wanted count, the lowest code wins.
- R5: A shortfall in room moves the thread to Blocked on the next cycle. The block output is high in Blocked, Unblocking and SerializeStall.
- R6: When the source is decode, the push count is the decode arrivals minus the grant. When the source is the skid buffer, the push count is all the arrivals and the pop count equals the grant.
- R7: Blocked moves to Unblocking once no stall request is present and room suffices. Unblocking moves to Running only in a cycle whose grant empties the skid buffer, and block falls when Running is reached.
- R8: While a stall request is present (and no squash), the grant is zero, all arrivals are pushed, and the thread is Blocked from the next cycle.
- R9: A serializing head met while the reorder buffer is not empty or the in-flight count is nonzero gives a grant of zero and the SerializeStall state. SerializeStall returns to Running once both conditions hold. A serializing head with both conditions already true renames alone, with a grant of 1.
- R10: A serialize-after marker makes the next instruction to rename be handled as serializing. The marker is cleared once that instruction renames.
- R11: A squash request forces a zero grant in its own cycle. The flush output is high in the following cycle (StartSquash), then follows one Squashing cycle and then Running. Grant and push stay zero throughout.
- R12: The activity flag is high when any thread is not Idle. Running with no source and no stall request returns to Idle, and Idle renames like Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| squash_i | input | NTHR | Per-thread squash request |
| stall_i | input | NTHR | Per-thread stall request from later stages |
| rob_empty_i | input | NTHR | Reorder buffer holds nothing for this thread |
| barrier_i | input | NTHR | Oldest waiting instruction is serializing |
| ser_after_i | input | NTHR | A renamed instruction marks the next one as serializing |
| dec_cnt_i | input | NTHR x CNT_W | Instructions arriving from decode |
| skid_cnt_i | input | NTHR x SKID_W | Current skid buffer occupancy |
| retire_i | input | NTHR x FREE_W | In-flight instructions now counted downstream |
| rob_free_i | input | NTHR x FREE_W | Free reorder buffer entries |
| iq_free_i | input | NTHR x FREE_W | Free issue queue entries |
| lsq_free_i | input | NTHR x FREE_W | Free load/store queue entries |
| grant_o | output | NTHR x CNT_W | Instructions allowed to rename this cycle |
| skid_push_o | output | NTHR x CNT_W | Arrivals to write into the skid buffer |
| skid_pop_o | output | NTHR x CNT_W | Entries to remove from the skid buffer |
| skid_flush_o | output | NTHR | Clear the skid buffer (StartSquash) |
| dec_block_o | output | NTHR | Hold decode for this thread |
| cause_o | output | NTHR x 2 | Shortfall cause code |
| active_o | output | 1 | Any thread not Idle |

## Verification
A table of free counts and decode sizes is applied from a clean Running state. It contains cases where each structure alone runs short, where two or three run short together (this separates the priority order), where all have room, where there are zero arrivals, and where the width itself is the limit. Directed sequences then carry in-flight counts across cycles. These show that room is measured net of work already sent and that a nonzero count keeps a serializing instruction waiting even with an empty reorder buffer. Unblocking is tried with a skid fill larger than the width, so that a premature return to Running is visible. The serialize-after marker is tried on an instruction without a serializing head, and the check after the marker clears confirms that later instructions rename at full width.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [2:0] {
        TS_RUN      = 3'd0,
        TS_IDLE     = 3'd1,
        TS_SQ_START = 3'd2,
        TS_SQ       = 3'd3,
        TS_BLOCK    = 3'd4,
        TS_UNBLOCK  = 3'd5,
        TS_SER_WAIT = 3'd6
    } tstate_e;

    // Code order is the report priority
    typedef enum logic [1:0] {
        CAUSE_ROB  = 2'd0,
        CAUSE_IQ   = 2'd1,
        CAUSE_LSQ  = 2'd2,
        CAUSE_NONE = 2'd3
    } cause_e;

    localparam int NUM_STRUCT = 3;

    function automatic logic holds_decode(tstate_e s);
        return (s == TS_BLOCK) || (s == TS_UNBLOCK) || (s == TS_SER_WAIT);
    endfunction

endpackage

// File: rtl/rn_budget.sv
module rn_budget #(
    parameter int FREE_W = 6,
    parameter int CNT_W  = 3
) (
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] iq_free,
    input  logic [FREE_W-1:0] lsq_free,
    input  logic [FREE_W-1:0] inflight,
    input  logic [CNT_W-1:0]  want,
    output logic [CNT_W-1:0]  take,
    output rn_pkg::cause_e    cause
);
    import rn_pkg::*;

    logic [NUM_STRUCT-1:0][FREE_W-1:0] fr;
    logic [NUM_STRUCT-1:0][FREE_W-1:0] room;
    logic [NUM_STRUCT-1:0]             short_v;
    logic [FREE_W-1:0]                 want_w;
    logic [FREE_W-1:0]                 lim;

    assign fr[0]  = rob_free;
    assign fr[1]  = iq_free;
    assign fr[2]  = lsq_free;
    assign want_w = FREE_W'(want);

    for (genvar k = 0; k < NUM_STRUCT; k++) begin : g_room
        assign room[k]    = (fr[k] > inflight) ? fr[k] - inflight : '0;
        assign short_v[k] = room[k] < want_w;
    end

    always_comb begin
        lim = want_w;
        for (int k = 0; k < NUM_STRUCT; k++) begin
            if (room[k] < lim) lim = room[k];
        end
        take = CNT_W'(lim);
    end

    always_comb begin
        if (short_v[0])      cause = CAUSE_ROB;
        else if (short_v[1]) cause = CAUSE_IQ;
        else if (short_v[2]) cause = CAUSE_LSQ;
        else                 cause = CAUSE_NONE;
    end

endmodule

// File: rtl/rn_thread.sv
module rn_thread #(
    parameter int WIDTH  = 4,
    parameter int FREE_W = 6,
    parameter int CNT_W  = 3,
    parameter int SKID_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              squash,
    input  logic              stall,
    input  logic              rob_empty,
    input  logic              barrier,
    input  logic              ser_after,
    input  logic [CNT_W-1:0]  dec_cnt,
    input  logic [SKID_W-1:0] skid_cnt,
    input  logic [FREE_W-1:0] retire,
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] iq_free,
    input  logic [FREE_W-1:0] lsq_free,
    output logic [CNT_W-1:0]  grant,
    output logic [CNT_W-1:0]  push,
    output logic [CNT_W-1:0]  pop,
    output logic              flush,
    output logic              block,
    output logic              idle,
    output rn_pkg::cause_e    cause
);
    import rn_pkg::*;

    localparam logic [SKID_W-1:0] WIDTH_S = SKID_W'(WIDTH);

    tstate_e           st, nxt;
    logic [FREE_W-1:0] inflight;
    logic              ser_next;
    logic              from_skid;
    logic [SKID_W-1:0] src;
    logic [CNT_W-1:0]  want;
    logic [CNT_W-1:0]  take;
    logic              is_barrier;
    logic              drained;
    logic              short_any;
    logic [FREE_W:0]   sum;

    assign from_skid  = skid_cnt != '0;
    assign src        = from_skid ? skid_cnt : SKID_W'(dec_cnt);
    assign want       = (src > WIDTH_S) ? CNT_W'(WIDTH) : CNT_W'(src);
    assign is_barrier = barrier || ser_next;
    assign drained    = rob_empty && (inflight == '0);
    assign short_any  = cause != CAUSE_NONE;

    rn_budget #(.FREE_W(FREE_W), .CNT_W(CNT_W)) u_budget (
        .rob_free (rob_free),
        .iq_free  (iq_free),
        .lsq_free (lsq_free),
        .inflight (inflight),
        .want     (want),
        .take     (take),
        .cause    (cause)
    );

    always_comb begin
        nxt   = st;
        grant = '0;
        push  = '0;
        unique case (st)
            TS_SQ_START: nxt = TS_SQ;
            TS_SQ:       nxt = TS_RUN;
            TS_BLOCK: begin
                push = dec_cnt;
                if (!stall && !short_any) nxt = TS_UNBLOCK;
            end
            TS_SER_WAIT: begin
                push = dec_cnt;
                if (drained) nxt = TS_RUN;
            end
            default: begin
                if (stall) begin
                    push = dec_cnt;
                    nxt  = TS_BLOCK;
                end else if (want == '0) begin
                    nxt = (st == TS_UNBLOCK) ? TS_RUN : TS_IDLE;
                end else if (is_barrier && !drained) begin
                    push = dec_cnt;
                    nxt  = TS_SER_WAIT;
                end else begin
                    if (is_barrier) grant = (take != '0) ? CNT_W'(1) : '0;
                    else            grant = take;
                    push = from_skid ? dec_cnt : dec_cnt - grant;
                    if (short_any && !is_barrier)
                        nxt = TS_BLOCK;
                    else if (st == TS_UNBLOCK)
                        nxt = (!from_skid || skid_cnt == SKID_W'(grant)) ? TS_RUN : TS_UNBLOCK;
                    else
                        nxt = TS_RUN;
                end
            end
        endcase
        if (squash) begin
            nxt   = TS_SQ_START;
            grant = '0;
            push  = '0;
        end
    end

    assign pop   = from_skid ? grant : '0;
    assign flush = st == TS_SQ_START;
    assign block = holds_decode(st);
    assign idle  = st == TS_IDLE;
    assign sum   = {1'b0, inflight} + (FREE_W+1)'(grant);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TS_IDLE;
            inflight <= '0;
            ser_next <= 1'b0;
        end else begin
            st <= nxt;
            if (squash)
                inflight <= '0;
            else if (sum > (FREE_W+1)'(retire))
                inflight <= FREE_W'(sum - (FREE_W+1)'(retire));
            else
                inflight <= '0;
            if (squash)                           ser_next <= 1'b0;
            else if (ser_after)                   ser_next <= 1'b1;
            else if (grant != '0 && is_barrier)   ser_next <= 1'b0;
        end
    end

endmodule

// File: rtl/rename_ctrl.sv
module rename_ctrl #(
    parameter int NTHR       = 2,
    parameter int WIDTH      = 4,
    parameter int FREE_W     = 6,
    parameter int SKID_DEPTH = 8,
    localparam int CNT_W     = $clog2(WIDTH + 1),
    localparam int SKID_W    = $clog2(SKID_DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NTHR-1:0]              squash_i,
    input  logic [NTHR-1:0]              stall_i,
    input  logic [NTHR-1:0]              rob_empty_i,
    input  logic [NTHR-1:0]              barrier_i,
    input  logic [NTHR-1:0]              ser_after_i,
    input  logic [NTHR-1:0][CNT_W-1:0]   dec_cnt_i,
    input  logic [NTHR-1:0][SKID_W-1:0]  skid_cnt_i,
    input  logic [NTHR-1:0][FREE_W-1:0]  retire_i,
    input  logic [NTHR-1:0][FREE_W-1:0]  rob_free_i,
    input  logic [NTHR-1:0][FREE_W-1:0]  iq_free_i,
    input  logic [NTHR-1:0][FREE_W-1:0]  lsq_free_i,
    output logic [NTHR-1:0][CNT_W-1:0]   grant_o,
    output logic [NTHR-1:0][CNT_W-1:0]   skid_push_o,
    output logic [NTHR-1:0][CNT_W-1:0]   skid_pop_o,
    output logic [NTHR-1:0]              skid_flush_o,
    output logic [NTHR-1:0]              dec_block_o,
    output logic [NTHR-1:0][1:0]         cause_o,
    output logic                         active_o
);
    import rn_pkg::*;

    logic [NTHR-1:0] idle_v;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        cause_e cz;
        rn_thread #(
            .WIDTH(WIDTH), .FREE_W(FREE_W), .CNT_W(CNT_W), .SKID_W(SKID_W)
        ) u_thr (
            .clk       (clk),
            .rst       (rst),
            .squash    (squash_i[t]),
            .stall     (stall_i[t]),
            .rob_empty (rob_empty_i[t]),
            .barrier   (barrier_i[t]),
            .ser_after (ser_after_i[t]),
            .dec_cnt   (dec_cnt_i[t]),
            .skid_cnt  (skid_cnt_i[t]),
            .retire    (retire_i[t]),
            .rob_free  (rob_free_i[t]),
            .iq_free   (iq_free_i[t]),
            .lsq_free  (lsq_free_i[t]),
            .grant     (grant_o[t]),
            .push      (skid_push_o[t]),
            .pop       (skid_pop_o[t]),
            .flush     (skid_flush_o[t]),
            .block     (dec_block_o[t]),
            .idle      (idle_v[t]),
            .cause     (cz)
        );
        assign cause_o[t] = cz;
    end

    assign active_o = ~&idle_v;

endmodule

// File: rtl/rename_ctrl_chk.sv
module rename_ctrl_chk #(
    parameter int NTHR   = 2,
    parameter int WIDTH  = 4,
    parameter int FREE_W = 6,
    parameter int CNT_W  = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NTHR-1:0]            squash_i,
    input logic [NTHR-1:0]            stall_i,
    input logic [NTHR-1:0][FREE_W-1:0] rob_free_i,
    input logic [NTHR-1:0][CNT_W-1:0] grant_o,
    input logic [NTHR-1:0][CNT_W-1:0] skid_push_o,
    input logic [NTHR-1:0][CNT_W-1:0] skid_pop_o,
    input logic [NTHR-1:0]            skid_flush_o
);
    for (genvar t = 0; t < NTHR; t++) begin : g_chk
        assert_grant_width_R2: assert property (@(posedge clk) disable iff (rst)
            grant_o[t] <= CNT_W'(WIDTH));
        assert_grant_room_R3: assert property (@(posedge clk) disable iff (rst)
            FREE_W'(grant_o[t]) <= rob_free_i[t]);
        assert_pop_le_grant_R6: assert property (@(posedge clk) disable iff (rst)
            skid_pop_o[t] <= grant_o[t]);
        assert_stall_zero_R8: assert property (@(posedge clk) disable iff (rst)
            stall_i[t] |-> grant_o[t] == '0);
        assert_squash_flush_R11: assert property (@(posedge clk) disable iff (rst)
            squash_i[t] |=> skid_flush_o[t]);
        assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (rst)
            skid_flush_o[t] |-> (grant_o[t] == '0 && skid_push_o[t] == '0));
    end
endmodule

bind rename_ctrl rename_ctrl_chk #(
    .NTHR(NTHR), .WIDTH(WIDTH), .FREE_W(FREE_W), .CNT_W($clog2(WIDTH + 1))
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .squash_i     (squash_i),
    .stall_i      (stall_i),
    .rob_free_i   (rob_free_i),
    .grant_o      (grant_o),
    .skid_push_o  (skid_push_o),
    .skid_pop_o   (skid_pop_o),
    .skid_flush_o (skid_flush_o)
);

// File: tb/test_rename_ctrl.sv
`timescale 1ns/1ps
module test_rename_ctrl;
    localparam int NTHR = 2, WIDTH = 4, FREE_W = 6, SKID_DEPTH = 8;
    localparam int CNT_W = $clog2(WIDTH + 1), SKID_W = $clog2(SKID_DEPTH + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic [NTHR-1:0] squash, stall, rob_empty, barrier, ser_after;
    logic [NTHR-1:0][CNT_W-1:0]  dec_cnt;
    logic [NTHR-1:0][SKID_W-1:0] skid_cnt;
    logic [NTHR-1:0][FREE_W-1:0] retire, rob_free, iq_free, lsq_free;
    logic [NTHR-1:0][CNT_W-1:0]  grant, push, pop;
    logic [NTHR-1:0]             flush, block;
    logic [NTHR-1:0][1:0]        cause;
    logic                        active;

    int checks = 0, fails = 0;
    bit done = 0;

    // rob, iq, lsq, decode count, expected grant, expected cause
    localparam int VEC [9][6] = '{
        '{10, 10, 10, 3, 3, 3},
        '{ 2, 10, 10, 3, 2, 0},
        '{10,  1, 10, 4, 1, 1},
        '{10, 10,  0, 2, 0, 2},
        '{ 1,  1,  0, 4, 0, 0},
        '{10,  2,  1, 3, 1, 1},
        '{10, 10, 10, 0, 0, 3},
        '{ 4,  4,  4, 4, 4, 3},
        '{63, 63, 63, 4, 4, 3}
    };

    always #2 clk = ~clk;

    rename_ctrl #(.NTHR(NTHR), .WIDTH(WIDTH), .FREE_W(FREE_W), .SKID_DEPTH(SKID_DEPTH)) i_rename_ctrl (
        .clk(clk), .rst(rst), .squash_i(squash), .stall_i(stall), .rob_empty_i(rob_empty),
        .barrier_i(barrier), .ser_after_i(ser_after), .dec_cnt_i(dec_cnt), .skid_cnt_i(skid_cnt),
        .retire_i(retire), .rob_free_i(rob_free), .iq_free_i(iq_free), .lsq_free_i(lsq_free),
        .grant_o(grant), .skid_push_o(push), .skid_pop_o(pop), .skid_flush_o(flush),
        .dec_block_o(block), .cause_o(cause), .active_o(active)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_free(input int r, input int q, input int l);
        rob_free[0] = FREE_W'(r);
        iq_free[0]  = FREE_W'(q);
        lsq_free[0] = FREE_W'(l);
    endtask

    task automatic do_squash();
        squash[0] = 1'b1; dec_cnt[0] = '0; skid_cnt[0] = '0; barrier[0] = 1'b0;
        stall[0] = 1'b0; retire[0] = '0; set_free(10, 10, 10);
        step();
        squash[0] = 1'b0;
        step();
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        squash = '0; stall = '0; rob_empty = '0; barrier = '0; ser_after = '0;
        dec_cnt = '0; skid_cnt = '0; retire = '0;
        for (int t = 0; t < NTHR; t++) begin
            rob_free[t] = 10; iq_free[t] = 10; lsq_free[t] = 10;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 active", int'(active), 0);
        chk("R1 block", int'(block[0]), 0);
        chk("R1 flush", int'(flush[0]), 0);
        chk("R1 grant", int'(grant[0]), 0);

        // Table walk: budget and cause priority
        for (int v = 0; v < 9; v++) begin
            set_free(VEC[v][0], VEC[v][1], VEC[v][2]);
            dec_cnt[0] = CNT_W'(VEC[v][3]);
            #1;
            chk("R2 grant", int'(grant[0]), VEC[v][4]);
            chk("R4 cause", int'(cause[0]), VEC[v][5]);
            step();
            dec_cnt[0] = '0; set_free(10, 10, 10); squash[0] = 1'b1;
            step();
            squash[0] = 1'b0;
            #1;
            chk("R11 flush", int'(flush[0]), 1);
            step();
            step();
        end

        // In-flight subtraction, block, unblock
        dec_cnt[0] = 3; #1;
        chk("R2 grant", int'(grant[0]), 3);
        step();
        dec_cnt[0] = 4; set_free(5, 10, 10); #1;
        chk("R3 grant", int'(grant[0]), 2);
        chk("R4 cause", int'(cause[0]), 0);
        chk("R6 push", int'(push[0]), 2);
        step();
        dec_cnt[0] = 0; set_free(10, 10, 10); skid_cnt[0] = 2; #1;
        chk("R5 block", int'(block[0]), 1);
        chk("R5 grant", int'(grant[0]), 0);
        step();
        #1;
        chk("R7 block", int'(block[0]), 1);
        chk("R7 grant", int'(grant[0]), 2);
        chk("R6 pop", int'(pop[0]), 2);
        step();
        skid_cnt[0] = 0; #1;
        chk("R7 release", int'(block[0]), 0);

        // Squash override and sequence
        squash[0] = 1'b1; dec_cnt[0] = 2; #1;
        chk("R11 override", int'(grant[0]), 0);
        step();
        squash[0] = 1'b0; #1;
        chk("R11 flush", int'(flush[0]), 1);
        chk("R11 grant", int'(grant[0]), 0);
        chk("R11 push", int'(push[0]), 0);
        step();
        #1;
        chk("R11 squashing flush", int'(flush[0]), 0);
        chk("R11 squashing grant", int'(grant[0]), 0);
        step();
        #1;
        chk("R11 resume", int'(grant[0]), 2);
        step();
        do_squash();

        // Stall request and long unblock
        stall[0] = 1'b1; dec_cnt[0] = 3; #1;
        chk("R8 grant", int'(grant[0]), 0);
        chk("R8 push", int'(push[0]), 3);
        step();
        dec_cnt[0] = 0; skid_cnt[0] = 3; #1;
        chk("R8 block", int'(block[0]), 1);
        step();
        stall[0] = 1'b0; skid_cnt[0] = 6; #1;
        chk("R8 blocked grant", int'(grant[0]), 0);
        step();
        #1;
        chk("R7 grant width", int'(grant[0]), 4);
        chk("R7 pop", int'(pop[0]), 4);
        step();
        skid_cnt[0] = 2; #1;
        chk("R7 still unblocking", int'(block[0]), 1);
        chk("R7 grant", int'(grant[0]), 2);
        step();
        skid_cnt[0] = 0; #1;
        chk("R7 release", int'(block[0]), 0);
        do_squash();

        // Serializing instruction
        rob_empty[0] = 1'b0; barrier[0] = 1'b1; dec_cnt[0] = 2; #1;
        chk("R9 grant", int'(grant[0]), 0);
        chk("R9 push", int'(push[0]), 2);
        step();
        dec_cnt[0] = 0; skid_cnt[0] = 2; rob_empty[0] = 1'b1; #1;
        chk("R9 block", int'(block[0]), 1);
        chk("R9 wait grant", int'(grant[0]), 0);
        step();
        #1;
        chk("R9 release", int'(block[0]), 0);
        chk("R9 alone", int'(grant[0]), 1);
        chk("R9 pop", int'(pop[0]), 1);
        step();
        skid_cnt[0] = 1; #1;
        chk("R9 inflight holds", int'(grant[0]), 0);
        step();
        retire[0] = 1; #1;
        chk("R9 waiting", int'(block[0]), 1);
        step();
        retire[0] = 0; #1;
        chk("R9 waiting grant", int'(grant[0]), 0);
        step();
        #1;
        chk("R9 renamed", int'(grant[0]), 1);
        step();
        barrier[0] = 1'b0; rob_empty[0] = 1'b0;
        do_squash();

        // Serialize-after marker
        ser_after[0] = 1'b1; dec_cnt[0] = 1; rob_empty[0] = 1'b0; #1;
        chk("R10 marker inst", int'(grant[0]), 1);
        step();
        ser_after[0] = 1'b0; #1;
        chk("R10 next held", int'(grant[0]), 0);
        chk("R10 push", int'(push[0]), 1);
        step();
        dec_cnt[0] = 0; rob_empty[0] = 1'b1; retire[0] = 1;
        step();
        retire[0] = 0;
        step();
        skid_cnt[0] = 1; #1;
        chk("R10 renamed alone", int'(grant[0]), 1);
        step();
        skid_cnt[0] = 0; dec_cnt[0] = 2; rob_empty[0] = 1'b0; #1;
        chk("R10 marker cleared", int'(grant[0]), 2);
        step();
        do_squash();

        // Activity flag
        dec_cnt[0] = 0;
        step();
        #1;
        chk("R12 idle", int'(active), 0);
        dec_cnt[0] = 1; #1;
        chk("R12 idle renames", int'(grant[0]), 1);
        step();
        dec_cnt[0] = 0; #1;
        chk("R12 active", int'(active), 1);
        step();
        #1;
        chk("R12 back idle", int'(active), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule